// File: doc/BRIEF.md
# Interrupt Source Configuration Bank

This block holds the per-source configuration and status of up to `NUM_SRC` interrupt sources, and a small byte-addressed register window through which software reads and changes them. For each source it keeps an enable bit, a pending bit, an 8-bit priority, an 8-bit target mask, a handling-model bit and an edge/level bit. It also watches the external interrupt lines. The first external line belongs to source 32, because sources 0 to 31 are reserved for software and internal use.

The register window is 4 KB wide and is reached over a simple single-cycle bus. A 32-bit access carries four little-endian byte lanes that are gated by byte enables, and each lane is decoded on its own as a byte address. Writes take effect at the next clock edge. Read data is combinational from the address. The block exports all state as flat vectors to the arbitration and acknowledge logic that follows it, and it takes the active bits back from that logic as an input to show on reads. A software trigger word at offset 0xF00 and eight identification bytes complete the window.

Top module: `irq_dist_bank`

## Requirements
- R1: After reset, every per-source enable, pending, priority, target, model, edge and stored-level bit is zero, and the global enable is zero.
- R2: Bit 0 of byte 0x000 is the global enable, readable and writable. A read of byte 0x004 returns NUM_SRC/32 − 1. Other bytes below 0x100 read zero.
- R3: A one written to bit s%8 of byte 0x100+s/8 sets the enable of source s. A one at the same position in byte 0x180+s/8 clears it. Zero bits have no effect. Both windows read back the current enable bits.
- R4: Bytes 0x200+s/8 and 0x280+s/8 set and clear pending in the same way and read back the pending bits. Bytes 0x300+s/8 read the active input `src_active_i`. Writes there change nothing.
- R5: Byte 0x400+s is the priority of source s and byte 0x800+s is its target. Only the lanes whose byte enable is set are written.
- R6: Byte 0xC00+s/4 holds two bits per source at bit 2*(s%4). The lower bit is the model and the upper bit is edge (1) or level (0).
- R7: Setting the enable of a level-sensitive source whose stored line level is high also sets its pending bit. When the level is low, only the enable changes.
- R8: Line j of `ext_irq_i` drives source 32+j. The stored level follows the line each cycle. A low-to-high change sets pending when the source is edge-type or enabled. A line that stays at the same level has no effect.
- R9: A write to word 0xF00 with byte enables 1:0 both set sets pending on the source numbered by write data bits 9:0. Any other enable pattern, or a number at or above NUM_SRC, has no effect.
- R10: Bytes 0xFE0+4k (k = 0..7) read 0x90, 0x13, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in order of k. The other three bytes of each of those words read zero.
- R11: Bytes that address sources at or above NUM_SRC, the unused areas, and the software trigger word all read zero. Writes to them change no state.
- R12: A pending-set event and a pending-clear write for the same source in the same cycle leave the source pending.

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_sel_i | input | 1 | Bus access valid |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address within the window (word-aligned use) |
| bus_be_i | input | 4 | Byte lane enables for writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, zero when no read is in progress |
| ext_irq_i | input | NUM_SRC-32 | External interrupt lines, line j to source 32+j |
| src_active_i | input | NUM_SRC | Active bits from the acknowledge logic, shown on reads |
| dist_en_o | output | 1 | Global enable |
| src_en_o | output | NUM_SRC | Per-source enable |
| src_pend_o | output | NUM_SRC | Per-source pending |
| src_edge_o | output | NUM_SRC | Per-source edge-type flag |
| src_model_o | output | NUM_SRC | Per-source handling model bit |
| src_prio_o | output | 8*NUM_SRC | Priority bytes, source s at bits 8s+7:8s |
| src_tgt_o | output | 8*NUM_SRC | Target bytes, source s at bits 8s+7:8s |

## Verification
The assertions assume that the external lines are synchronous to `clk` and stable around its rising edge. They also assume that a bus write lasts exactly the cycles in which `bus_sel_i` and `bus_wr_i` are both high. The check that pending holds steady while the lines are quiet counts only from the second cycle after reset release, so a line that is already high during reset cannot break it. The bench meets these assumptions by changing every input only on the falling edge. It holds the lines low through reset and drops the select after every access.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;

  localparam int OFS_CTRL    = 'h000;
  localparam int OFS_INFO    = 'h004;
  localparam int OFS_EN_SET  = 'h100;
  localparam int OFS_EN_CLR  = 'h180;
  localparam int OFS_PD_SET  = 'h200;
  localparam int OFS_PD_CLR  = 'h280;
  localparam int OFS_ACT     = 'h300;
  localparam int OFS_PRIO    = 'h400;
  localparam int OFS_TGT     = 'h800;
  localparam int OFS_CFG     = 'hC00;
  localparam int OFS_SOFT    = 'hF00;
  localparam int OFS_IDENT   = 'hFE0;

  typedef logic [7:0] byte_t;

  // Identification byte k, placed in lane 0 of word OFS_IDENT + 4k
  function automatic byte_t ident_byte(input logic [2:0] k);
    case (k)
      3'd0:    return 8'h90;
      3'd1:    return 8'h13;
      3'd2:    return 8'h04;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/irq_src_cell.sv
// State of one interrupt source. All address constants come from SRC_ID.
module irq_src_cell
  import irq_dist_pkg::*;
#(
  parameter int SRC_ID   = 0,
  parameter bit HAS_LINE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stb,
  input  logic [9:0]  wr_word,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  input  logic        soft_set,
  input  logic        line_i,
  output logic        en_o,
  output logic        pend_o,
  output logic        edge_o,
  output logic        model_o,
  output byte_t       prio_o,
  output byte_t       tgt_o
);

  localparam int EN_BYTE  = SRC_ID / 8;
  localparam int EN_LANE  = EN_BYTE % 4;
  localparam int EN_POS   = 8 * EN_LANE + SRC_ID % 8;
  localparam int BY_LANE  = SRC_ID % 4;
  localparam int CFG_BYTE = SRC_ID / 4;
  localparam int CFG_LANE = CFG_BYTE % 4;
  localparam int CFG_POS  = 8 * CFG_LANE + 2 * (SRC_ID % 4);

  localparam logic [9:0] W_EN_SET = 10'((OFS_EN_SET + EN_BYTE) / 4);
  localparam logic [9:0] W_EN_CLR = 10'((OFS_EN_CLR + EN_BYTE) / 4);
  localparam logic [9:0] W_PD_SET = 10'((OFS_PD_SET + EN_BYTE) / 4);
  localparam logic [9:0] W_PD_CLR = 10'((OFS_PD_CLR + EN_BYTE) / 4);
  localparam logic [9:0] W_PRIO   = 10'((OFS_PRIO + SRC_ID) / 4);
  localparam logic [9:0] W_TGT    = 10'((OFS_TGT + SRC_ID) / 4);
  localparam logic [9:0] W_CFG    = 10'((OFS_CFG + CFG_BYTE) / 4);

  logic  en_q, pend_q, edge_q, model_q;
  byte_t prio_q, tgt_q;
  logic  en_d, pend_d;
  logic  set_en, clr_en, set_pd, clr_pd;
  logic  ld_prio, ld_tgt, ld_cfg;
  logic  lvl_now, rise;
  logic  pend_set;

  logic unused_wr;
  assign unused_wr = ^{wr_data, wr_be, wr_word};

  assign set_en  = wr_stb && (wr_word == W_EN_SET) && wr_be[EN_LANE] && wr_data[EN_POS];
  assign clr_en  = wr_stb && (wr_word == W_EN_CLR) && wr_be[EN_LANE] && wr_data[EN_POS];
  assign set_pd  = wr_stb && (wr_word == W_PD_SET) && wr_be[EN_LANE] && wr_data[EN_POS];
  assign clr_pd  = wr_stb && (wr_word == W_PD_CLR) && wr_be[EN_LANE] && wr_data[EN_POS];
  assign ld_prio = wr_stb && (wr_word == W_PRIO) && wr_be[BY_LANE];
  assign ld_tgt  = wr_stb && (wr_word == W_TGT) && wr_be[BY_LANE];
  assign ld_cfg  = wr_stb && (wr_word == W_CFG) && wr_be[CFG_LANE];

  generate
    if (HAS_LINE) begin : g_line
      logic lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= line_i;
      end
      assign lvl_now = lvl_q;
      assign rise    = line_i & ~lvl_q;
    end else begin : g_noline
      logic unused_line;
      assign unused_line = line_i;
      assign lvl_now = 1'b0;
      assign rise    = 1'b0;
    end
  endgenerate

  // Next state: every set source wins over a same-cycle clear
  always_comb begin
    pend_set = set_pd | soft_set
             | (rise & (edge_q | en_q))
             | (set_en & lvl_now & ~edge_q);
    pend_d   = pend_set | (pend_q & ~clr_pd);
    en_d     = set_en | (en_q & ~clr_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
      edge_q  <= 1'b0;
      model_q <= 1'b0;
      prio_q  <= '0;
      tgt_q   <= '0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      if (ld_prio) prio_q <= wr_data[8*BY_LANE +: 8];
      if (ld_tgt)  tgt_q  <= wr_data[8*BY_LANE +: 8];
      if (ld_cfg) begin
        model_q <= wr_data[CFG_POS];
        edge_q  <= wr_data[CFG_POS+1];
      end
    end
  end

  assign en_o    = en_q;
  assign pend_o  = pend_q;
  assign edge_o  = edge_q;
  assign model_o = model_q;
  assign prio_o  = prio_q;
  assign tgt_o   = tgt_q;

endmodule

// File: rtl/irq_soft_decode.sv
// Software trigger word: one-hot pending request from a halfword write.
module irq_soft_decode
  import irq_dist_pkg::*;
#(
  parameter int NUM_SRC = 96
) (
  input  logic               wr_stb,
  input  logic [9:0]         wr_word,
  input  logic [3:0]         wr_be,
  input  logic [31:0]        wr_data,
  output logic [NUM_SRC-1:0] soft_vec
);

  localparam logic [9:0] W_SOFT = 10'(OFS_SOFT / 4);

  logic hit;
  logic unused_soft;
  assign unused_soft = ^{wr_be[3:2], wr_data[31:10]};
  assign hit = wr_stb && (wr_word == W_SOFT) && (wr_be[1:0] == 2'b11);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_dec
    assign soft_vec[s] = hit && (wr_data[9:0] == 10'(s));
  end

endmodule

// File: rtl/irq_read_mux.sv
// Per-lane byte read decode over the whole window.
module irq_read_mux
  import irq_dist_pkg::*;
#(
  parameter int NUM_SRC = 96
) (
  input  logic [9:0]           rd_word,
  input  logic                 dist_en,
  input  logic [NUM_SRC-1:0]   en,
  input  logic [NUM_SRC-1:0]   pend,
  input  logic [NUM_SRC-1:0]   act,
  input  logic [NUM_SRC-1:0]   edg,
  input  logic [NUM_SRC-1:0]   model,
  input  logic [8*NUM_SRC-1:0] prio,
  input  logic [8*NUM_SRC-1:0] tgt,
  output logic [31:0]          rdata
);

  localparam byte_t GROUPS = byte_t'(NUM_SRC / 32 - 1);

  logic [11:0] ba;
  byte_t       bv;
  int          idx;

  always_comb begin
    rdata = '0;
    ba    = '0;
    bv    = '0;
    idx   = 0;
    for (int lane = 0; lane < 4; lane++) begin
      ba = {rd_word, lane[1:0]};
      bv = '0;
      if (ba < 12'(OFS_EN_SET)) begin
        if (ba == 12'(OFS_CTRL))      bv = {7'b0, dist_en};
        else if (ba == 12'(OFS_INFO)) bv = GROUPS;
      end else if (ba < 12'(OFS_PD_SET)) begin
        for (int b = 0; b < 8; b++) begin
          idx = int'(ba[6:0]) * 8 + b;
          if (idx < NUM_SRC) bv[b] = en[idx];
        end
      end else if (ba < 12'(OFS_ACT)) begin
        for (int b = 0; b < 8; b++) begin
          idx = int'(ba[6:0]) * 8 + b;
          if (idx < NUM_SRC) bv[b] = pend[idx];
        end
      end else if (ba < 12'(OFS_PRIO)) begin
        for (int b = 0; b < 8; b++) begin
          idx = int'(ba[7:0]) * 8 + b;
          if (idx < NUM_SRC) bv[b] = act[idx];
        end
      end else if (ba < 12'(OFS_TGT)) begin
        idx = int'(ba[9:0]);
        if (idx < NUM_SRC) bv = prio[idx*8 +: 8];
      end else if (ba < 12'(OFS_CFG)) begin
        idx = int'(ba[9:0]);
        if (idx < NUM_SRC) bv = tgt[idx*8 +: 8];
      end else if (ba < 12'(OFS_SOFT)) begin
        for (int k = 0; k < 4; k++) begin
          idx = int'(ba[9:0]) * 4 + k;
          if (idx < NUM_SRC) begin
            bv[2*k]   = model[idx];
            bv[2*k+1] = edg[idx];
          end
        end
      end else if (ba >= 12'(OFS_IDENT) && ba[1:0] == 2'b00) begin
        bv = ident_byte(ba[4:2]);
      end
      rdata[8*lane +: 8] = bv;
    end
  end

endmodule

// File: rtl/irq_dist_bank.sv
module irq_dist_bank
  import irq_dist_pkg::*;
#(
  parameter int NUM_SRC = 96
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel_i,
  input  logic                 bus_wr_i,
  input  logic [11:0]          bus_addr_i,
  input  logic [3:0]           bus_be_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  input  logic [NUM_SRC-33:0]  ext_irq_i,
  input  logic [NUM_SRC-1:0]   src_active_i,
  output logic                 dist_en_o,
  output logic [NUM_SRC-1:0]   src_en_o,
  output logic [NUM_SRC-1:0]   src_pend_o,
  output logic [NUM_SRC-1:0]   src_edge_o,
  output logic [NUM_SRC-1:0]   src_model_o,
  output logic [8*NUM_SRC-1:0] src_prio_o,
  output logic [8*NUM_SRC-1:0] src_tgt_o
);

  localparam int NUM_INT = 32;
  localparam logic [9:0] W_CTRL = 10'(OFS_CTRL / 4);

  logic               wr_stb;
  logic [9:0]         word;
  logic [NUM_SRC-1:0] soft_vec;
  logic [31:0]        rd_val;
  logic               dist_q, dist_d, ld_ctrl;
  logic unused_addr;

  assign unused_addr = ^bus_addr_i[1:0];
  assign wr_stb      = bus_sel_i & bus_wr_i;
  assign word        = bus_addr_i[11:2];

  // Global enable
  assign ld_ctrl = wr_stb && (word == W_CTRL) && bus_be_i[0];
  always_comb begin
    dist_d = dist_q;
    if (ld_ctrl) dist_d = bus_wdata_i[0];
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dist_q <= 1'b0;
    else        dist_q <= dist_d;
  end
  assign dist_en_o = dist_q;

  irq_soft_decode #(.NUM_SRC(NUM_SRC)) u_soft (
    .wr_stb  (wr_stb),
    .wr_word (word),
    .wr_be   (bus_be_i),
    .wr_data (bus_wdata_i),
    .soft_vec(soft_vec)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic line;
    if (s >= NUM_INT) begin : g_ext
      assign line = ext_irq_i[s-NUM_INT];
    end else begin : g_int
      assign line = 1'b0;
    end
    irq_src_cell #(.SRC_ID(s), .HAS_LINE(s >= NUM_INT)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .wr_word (word),
      .wr_be   (bus_be_i),
      .wr_data (bus_wdata_i),
      .soft_set(soft_vec[s]),
      .line_i  (line),
      .en_o    (src_en_o[s]),
      .pend_o  (src_pend_o[s]),
      .edge_o  (src_edge_o[s]),
      .model_o (src_model_o[s]),
      .prio_o  (src_prio_o[8*s +: 8]),
      .tgt_o   (src_tgt_o[8*s +: 8])
    );
  end

  irq_read_mux #(.NUM_SRC(NUM_SRC)) u_rd (
    .rd_word(word),
    .dist_en(dist_q),
    .en     (src_en_o),
    .pend   (src_pend_o),
    .act    (src_active_i),
    .edg    (src_edge_o),
    .model  (src_model_o),
    .prio   (src_prio_o),
    .tgt    (src_tgt_o),
    .rdata  (rd_val)
  );

  assign bus_rdata_o = (bus_sel_i && !bus_wr_i) ? rd_val : 32'h0;

endmodule

// File: rtl/irq_dist_bank_chk.sv
module irq_dist_bank_chk #(
  parameter int NUM_SRC = 96
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel_i,
  input logic                bus_wr_i,
  input logic [11:0]         bus_addr_i,
  input logic [3:0]          bus_be_i,
  input logic [31:0]         bus_wdata_i,
  input logic [NUM_SRC-33:0] ext_irq_i,
  input logic                dist_en_o,
  input logic [NUM_SRC-1:0]  src_en_o,
  input logic [NUM_SRC-1:0]  src_pend_o,
  input logic [NUM_SRC-1:0]  src_edge_o
);

  logic wr_now;
  assign wr_now = bus_sel_i && bus_wr_i;

  a_r2_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now && bus_addr_i == 12'h000 && bus_be_i[0]
    |=> dist_en_o == $past(bus_wdata_i[0]));

  a_r3_set_en0: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now && bus_addr_i == 12'h100 && bus_be_i[0] && bus_wdata_i[0]
    |=> src_en_o[0]);

  a_r3_clr_en0: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now && bus_addr_i == 12'h180 && bus_be_i[0] && bus_wdata_i[0]
    |=> !src_en_o[0]);

  a_r9_soft_src0: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now && bus_addr_i == 12'hF00 && bus_be_i[1:0] == 2'b11 && bus_wdata_i[9:0] == 10'd0
    |=> src_pend_o[0]);

  a_r8_edge_first_line: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ext_irq_i[0] && !$past(ext_irq_i[0]) && src_edge_o[32]
    |=> src_pend_o[32]);

  a_r8_quiet_lines: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !wr_now && ext_irq_i == $past(ext_irq_i)
    |=> $stable(src_pend_o));

endmodule

bind irq_dist_bank irq_dist_bank_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_sel_i  (bus_sel_i),
  .bus_wr_i   (bus_wr_i),
  .bus_addr_i (bus_addr_i),
  .bus_be_i   (bus_be_i),
  .bus_wdata_i(bus_wdata_i),
  .ext_irq_i  (ext_irq_i),
  .dist_en_o  (dist_en_o),
  .src_en_o   (src_en_o),
  .src_pend_o (src_pend_o),
  .src_edge_o (src_edge_o)
);

// File: tb/tb_irq_dist_bank.sv
`timescale 1ns/1ps
module tb_irq_dist_bank;

  localparam int N = 96;
  localparam int NE = N - 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel, wr;
  logic [11:0]   addr;
  logic [3:0]    be;
  logic [31:0]   wdata, rdata;
  logic [NE-1:0] ext;
  logic [N-1:0]  act;
  logic          dist_en;
  logic [N-1:0]  en_o, pend_o, edge_o, model_o;
  logic [8*N-1:0] prio_o, tgt_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [N-1:0] m_en, m_pend, m_edge, m_model;
  logic [7:0]   m_prio [N];
  logic [7:0]   m_tgt  [N];

  always #2 clk = ~clk;

  irq_dist_bank #(.NUM_SRC(N)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_be_i(be), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ext_irq_i(ext),
    .src_active_i(act), .dist_en_o(dist_en), .src_en_o(en_o), .src_pend_o(pend_o),
    .src_edge_o(edge_o), .src_model_o(model_o), .src_prio_o(prio_o), .src_tgt_o(tgt_o)
  );

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; be = 4'h0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk($sformatf("%s @%h", tag, a), d, exp);
  endtask

  task automatic set_line(input int j, input logic v);
    @(negedge clk);
    ext[j] = v;
    @(negedge clk);
  endtask

  function automatic logic [31:0] bits_word(input logic [N-1:0] v, input int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) if (32*w + b < N) r[b] = v[32*w + b];
    return r;
  endfunction

  function automatic logic [31:0] bytes_word(input int w, input bit tg);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++)
      if (4*w + k < N) r[8*k +: 8] = tg ? m_tgt[4*w+k] : m_prio[4*w+k];
    return r;
  endfunction

  function automatic logic [31:0] cfg_word(input int w);
    logic [31:0] r = '0;
    for (int k = 0; k < 16; k++)
      if (16*w + k < N) begin
        r[2*k]   = m_model[16*w+k];
        r[2*k+1] = m_edge[16*w+k];
      end
    return r;
  endfunction

  function automatic logic [7:0] id_exp(input int k);
    case (k)
      0: return 8'h90; 1: return 8'h13; 2: return 8'h04; 3: return 8'h00;
      4: return 8'h0D; 5: return 8'hF0; 6: return 8'h05; default: return 8'hB1;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] p;
    rst_n = 1'b0; sel = 0; wr = 0; addr = 0; be = 0; wdata = 0; ext = '0; act = '0;
    m_en = '0; m_pend = '0; m_edge = '0; m_model = '0;
    for (int s = 0; s < N; s++) begin m_prio[s] = 0; m_tgt[s] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int w = 0; w < 4; w++) begin
      rd_chk("R1 enable", 12'h100 + 12'(4*w), 0);
      rd_chk("R1 pending", 12'h200 + 12'(4*w), 0);
    end
    for (int w = 0; w < 25; w++) begin
      rd_chk("R1 priority", 12'h400 + 12'(4*w), 0);
      rd_chk("R1 target", 12'h800 + 12'(4*w), 0);
    end
    for (int w = 0; w < 7; w++) rd_chk("R1 config", 12'hC00 + 12'(4*w), 0);
    rd_chk("R1 ctrl", 12'h000, 0);
    chk("R1 outputs", {dist_en, en_o, pend_o}, 0);

    // R2: global enable and info word
    rd_chk("R2 info", 12'h004, N/32 - 1);
    bus_wr(12'h000, 32'h1, 4'h1);
    rd_chk("R2 ctrl set", 12'h000, 1);
    chk("R2 dist_en_o", dist_en, 1);
    bus_wr(12'h000, 32'h0, 4'h2);
    chk("R2 lane gate", dist_en, 1);
    rd_chk("R11 unused low", 12'h008, 0);

    // R3: enable set/clear windows
    for (int w = 0; w < 3; w++) begin
      p = 32'h9E3779B9 * (w + 1);
      bus_wr(12'h100 + 12'(4*w), p, 4'hF);
      m_en[32*w +: 32] |= p;
    end
    bus_wr(12'h100, 32'hFFFF_FFFF, 4'h4);
    m_en[23:16] = 8'hFF;
    for (int w = 0; w < 3; w++) begin
      p = 32'h0F0F33CC ^ (32'h11111111 << w);
      bus_wr(12'h180 + 12'(4*w), p, 4'hF);
      m_en[32*w +: 32] &= ~p;
    end
    for (int w = 0; w < 4; w++) begin
      rd_chk("R3 set window", 12'h100 + 12'(4*w), bits_word(m_en, w));
      rd_chk("R3 clear window", 12'h180 + 12'(4*w), bits_word(m_en, w));
    end
    chk("R3 src_en_o", en_o, m_en);

    // R4: pending windows and active bits
    for (int w = 0; w < 3; w++) begin
      p = 32'hC2B2AE35 * (w + 3);
      bus_wr(12'h200 + 12'(4*w), p, 4'hF);
      m_pend[32*w +: 32] |= p;
    end
    bus_wr(12'h284, 32'h00FF_00FF, 4'hF);
    m_pend[63:32] &= ~32'h00FF_00FF;
    for (int w = 0; w < 4; w++) begin
      rd_chk("R4 set window", 12'h200 + 12'(4*w), bits_word(m_pend, w));
      rd_chk("R4 clear window", 12'h280 + 12'(4*w), bits_word(m_pend, w));
    end
    act = {32'hDEADBEEF, 32'h12345678, 32'hA5A55A5A};
    for (int w = 0; w < 4; w++) rd_chk("R4 active", 12'h300 + 12'(4*w), bits_word(act, w));
    bus_wr(12'h300, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R4 active write ignored", 12'h300, bits_word(act, 0));
    chk("R4 active write state", {en_o, pend_o}, {m_en, m_pend});

    // R11: out-of-range sources
    bus_wr(12'h10C, 32'hFFFF_FFFF, 4'hF);
    rd_chk("R11 enable beyond", 12'h10C, 0);
    chk("R11 enable state", en_o, m_en);

    // clear enables and pending
    for (int w = 0; w < 3; w++) begin
      bus_wr(12'h180 + 12'(4*w), 32'hFFFF_FFFF, 4'hF);
      bus_wr(12'h280 + 12'(4*w), 32'hFFFF_FFFF, 4'hF);
    end
    m_en = '0; m_pend = '0;
    chk("R3 R4 cleared", {en_o, pend_o}, 0);

    // R5: priority and target bytes
    for (int w = 0; w < 25; w++) begin
      for (int k = 0; k < 4; k++) p[8*k +: 8] = 8'((4*w + k) * 7 + 3);
      bus_wr(12'h400 + 12'(4*w), p, 4'hF);
      bus_wr(12'h800 + 12'(4*w), p ^ 32'h5A5A5A5A, 4'hF);
      for (int k = 0; k < 4; k++) if (4*w + k < N) begin
        m_prio[4*w+k] = p[8*k +: 8];
        m_tgt[4*w+k]  = p[8*k +: 8] ^ 8'h5A;
      end
    end
    bus_wr(12'h404, 32'hFFFF_FFFF, 4'h2);
    m_prio[5] = 8'hFF;
    for (int w = 0; w < 25; w++) begin
      rd_chk("R5 priority", 12'h400 + 12'(4*w), bytes_word(w, 0));
      rd_chk("R5 target", 12'h800 + 12'(4*w), bytes_word(w, 1));
    end
    chk("R5 prio out 5", prio_o[8*5 +: 8], 8'hFF);
    chk("R5 tgt out 95", tgt_o[8*95 +: 8], m_tgt[95]);

    // R6: configuration pairs
    for (int w = 0; w < 7; w++) begin
      p = 32'h6C8E9CF5 * (w + 1);
      bus_wr(12'hC00 + 12'(4*w), p, 4'hF);
      for (int k = 0; k < 16; k++) if (16*w + k < N) begin
        m_model[16*w+k] = p[2*k];
        m_edge[16*w+k]  = p[2*k+1];
      end
    end
    for (int w = 0; w < 7; w++) rd_chk("R6 config", 12'hC00 + 12'(4*w), cfg_word(w));
    chk("R6 edge/model outputs", {edge_o, model_o}, {m_edge, m_model});
    for (int w = 0; w < 6; w++) bus_wr(12'hC00 + 12'(4*w), 32'h0, 4'hF);
    m_edge = '0; m_model = '0;

    // R8: source 41 (line 9) edge-type, disabled
    bus_wr(12'hC08, 32'h0008_0000, 4'h4);
    m_edge[41] = 1'b1;
    chk("R6 edge 41 set", edge_o, m_edge);
    set_line(9, 1'b1);
    m_pend[41] = 1'b1;
    rd_chk("R8 edge rise", 12'h204, bits_word(m_pend, 1));
    bus_wr(12'h284, 32'h1 << 9, 4'hF);
    m_pend[41] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 held line no effect", pend_o, m_pend);
    set_line(9, 1'b0);
    chk("R8 falling no effect", pend_o, m_pend);
    // level source 42 disabled: rise ignored
    set_line(10, 1'b1);
    chk("R8 disabled level rise", pend_o, m_pend);
    // R7: enabling it with high level sets pending
    bus_wr(12'h104, 32'h1 << 10, 4'hF);
    m_en[42] = 1'b1; m_pend[42] = 1'b1;
    chk("R7 enable with high level", {en_o, pend_o}, {m_en, m_pend});
    bus_wr(12'h284, 32'h1 << 10, 4'hF);
    m_pend[42] = 1'b0;
    chk("R8 held level after clear", pend_o, m_pend);
    // R7: enabling with low level leaves pending clear
    bus_wr(12'h104, 32'h1 << 12, 4'hF);
    m_en[44] = 1'b1;
    chk("R7 enable with low level", {en_o, pend_o}, {m_en, m_pend});
    // R8: enabled level source 43 rise
    bus_wr(12'h104, 32'h1 << 11, 4'hF);
    m_en[43] = 1'b1;
    set_line(11, 1'b1);
    m_pend[43] = 1'b1;
    chk("R8 enabled level rise", pend_o, m_pend);
    set_line(10, 1'b0);
    set_line(11, 1'b0);

    // R12: edge rise on 41 with same-cycle clear
    @(negedge clk);
    ext[9] = 1'b1;
    sel = 1'b1; wr = 1'b1; addr = 12'h284; wdata = 32'h1 << 9; be = 4'hF;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; be = 4'h0;
    m_pend[41] = 1'b1;
    chk("R12 set beats clear", pend_o, m_pend);
    set_line(9, 1'b0);

    // R9: software trigger word
    for (int w = 0; w < 3; w++) bus_wr(12'h280 + 12'(4*w), 32'hFFFF_FFFF, 4'hF);
    m_pend = '0;
    bus_wr(12'hF00, 32'd5, 4'h3);
    m_pend[5] = 1'b1;
    chk("R9 soft 5", pend_o, m_pend);
    bus_wr(12'hF00, 32'd95, 4'hF);
    m_pend[95] = 1'b1;
    chk("R9 soft 95", pend_o, m_pend);
    bus_wr(12'hF00, 32'd200, 4'h3);
    chk("R9 soft out of range", pend_o, m_pend);
    bus_wr(12'hF00, 32'd7, 4'h1);
    chk("R9 soft partial lanes", pend_o, m_pend);
    bus_wr(12'hF00, 32'h0000_0406, 4'h3);
    m_pend[6] = 1'b1;
    chk("R9 soft low ten bits", pend_o, m_pend);
    rd_chk("R11 soft word reads zero", 12'hF00, 0);

    // R10: identification bytes
    for (int k = 0; k < 8; k++) rd_chk("R10 ident", 12'hFE0 + 12'(4*k), {24'h0, id_exp(k)});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule